// File: doc/BRIEF.md
# Byte-Lane Data Access Unit with Alignment Trap

This unit connects a core's load/store path to a 16-bit data store. The store is built from two 8-bit lanes. Both lanes decode the same word index, and each lane has its own write enable. Addresses are byte addresses. The even byte of a word sits in the low lane and the odd byte sits in the high lane.

A byte access uses address bit 0 to choose a lane. A word access must use an even address. An odd-address word access raises an address-error trap:
- A faulting read still returns data.
- A faulting write is carried through, but no lane is written.

The trap is seen in two forms. One is a single-cycle pulse that carries the faulting address and a write flag. The other is a sticky status bit that stays set until software clears it.

A second request port serves the dual-operand prefetch path. That path only fetches words.

A small combinational step unit also scales pointer modification by operand size. It covers post-increment, post-decrement, pre-increment and pre-decrement.

Top module: `bytelane_access`

## Requirements
- R1: A word request (req_byte=0) at an even address writes req_wdata into both lanes. A word read at an even address returns the full word on rd_data, with rd_valid high in the cycle after the request.
- R2: A byte read returns the selected lane on rd_data[7:0] and zeros on rd_data[15:8], with rd_valid high in the cycle after the request. Address bit 0 = 0 selects word bits 7:0. Address bit 0 = 1 selects bits 15:8.
- R3: A byte write takes req_wdata[7:0]. It writes that value into bits 7:0 of the word when address bit 0 = 0, or into bits 15:8 when it is 1. The other lane keeps its value.
- R4: A word request at an odd address raises trap_pulse for exactly the cycle after the request. In that cycle trap_addr equals the request address. trap_is_write is 1 for a write and 0 for a read.
- R5: A misaligned word read still completes. rd_valid is high in the cycle after the request, and rd_data holds the full word whose index is the address with bit 0 dropped.
- R6: A misaligned word write changes no memory content.
- R7: trap_held rises together with trap_pulse and stays high until a cycle with trap_clear=1 and no new fault. If a fault and a clear happen in the same cycle, trap_held stays high.
- R8: A request with req_ypath=1 is always a word read. req_byte and req_write are ignored, and no lane is written.
- R9: Pointer step size is 1 when ptr_byte=1 and 2 when ptr_byte=0, with arithmetic modulo 2^AW. The ptr_mode encodings are:
  - 00 post-increment: ptr_ea=ptr_in, ptr_next=ptr_in+step.
  - 01 post-decrement: ptr_ea=ptr_in, ptr_next=ptr_in-step.
  - 10 pre-increment: ptr_ea=ptr_next=ptr_in+step.
  - 11 pre-decrement: ptr_ea=ptr_next=ptr_in-step.
- R10: While rst_n is low at a clock edge, rd_valid, trap_pulse, trap_held, trap_is_write and trap_addr become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_ypath | input | 1 | Request comes from the word-only prefetch path |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (bits 7:0 for byte writes) |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | rd_data holds a read result |
| trap_pulse | output | 1 | One-cycle address-error indication |
| trap_addr | output | AW | Address of the last fault |
| trap_is_write | output | 1 | Last fault was a write |
| trap_held | output | 1 | Sticky fault status |
| trap_clear | input | 1 | Clears trap_held |
| ptr_in | input | AW | Current pointer value |
| ptr_mode | input | 2 | Modify mode (see R9) |
| ptr_byte | input | 1 | Operand size for pointer step |
| ptr_ea | output | AW | Effective address to use |
| ptr_next | output | AW | Updated pointer value |

## Verification
The assertions assume that every access is a single-cycle request. They also assume that requests are not issued while reset is low. The stimulus keeps to this by driving one request per cycle, only after reset, and dropping req_valid between requests. Stored contents are never reset, so every word is written before the first read that is checked against the model. The pointer inputs are purely combinational; the bench sweeps every address, mode and size with no request in flight.

// File: rtl/bytelane_pkg.sv
// Shared types for the byte-lane access unit.
// Assumes a 16-bit word made of two 8-bit lanes.
package bytelane_pkg;
    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        PM_POST_INC = 2'b00,
        PM_POST_DEC = 2'b01,
        PM_PRE_INC  = 2'b10,
        PM_PRE_DEC  = 2'b11
    } ptr_mode_e;
endpackage

// File: rtl/bytelane_mem.sv
// Two-lane data store with a shared word index and one write enable per lane.
// The read word is registered and updates only when rd_en is high.
// Assumes a read and a write never target the same cycle.
module bytelane_mem
    import bytelane_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         lane_we,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORD_W-1:0]        rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [WORDS];
        logic [LANE_W-1:0] rd_q;

        // Lane write, then registered lane read.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store[idx] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                rd_q <= store[idx];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/bytelane_align.sv
// Decodes one access request into lane enables, read enable and a misalignment flag.
// Prefetch-path requests are forced to word reads.
// Assumes the request is valid for one cycle only.
module bytelane_align
    import bytelane_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_byte,
    input  logic             req_ypath,
    input  logic             addr_lsb,
    output logic             acc_write,
    output logic             acc_byte,
    output logic             misaligned,
    output logic             rd_en,
    output logic [LANES-1:0] lane_we
);
    // Effective access kind and fault detection.
    always_comb begin
        acc_write  = req_write & ~req_ypath;
        acc_byte   = req_byte  & ~req_ypath;
        misaligned = req_valid & ~acc_byte & addr_lsb;
        rd_en      = req_valid & ~acc_write;
    end

    // Lane write enables: a byte picks one lane, a fault suppresses both.
    always_comb begin
        lane_we = '0;
        if (req_valid && acc_write && !misaligned) begin
            if (acc_byte) begin
                lane_we[addr_lsb] = 1'b1;
            end else begin
                lane_we = '1;
            end
        end
    end
endmodule

// File: rtl/bytelane_step.sv
// Pointer modify unit: scales the step by operand size and forms the
// effective address and updated pointer for the four modify modes.
// Wraps modulo 2^AW.
module bytelane_step
    import bytelane_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic [AW-1:0] ptr_in,
    input  logic [1:0]    mode,
    input  logic          is_byte,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] next
);
    logic [AW-1:0] step;
    logic [AW-1:0] up;
    logic [AW-1:0] down;
    ptr_mode_e     pm;

    // Size-scaled neighbours of the pointer.
    always_comb begin
        step = is_byte ? AW'(1) : AW'(2);
        up   = ptr_in + step;
        down = ptr_in - step;
        pm   = ptr_mode_e'(mode);
    end

    // Mode select for address and writeback.
    always_comb begin
        unique case (pm)
            PM_POST_INC: begin ea = ptr_in; next = up;   end
            PM_POST_DEC: begin ea = ptr_in; next = down; end
            PM_PRE_INC:  begin ea = up;     next = up;   end
            default:     begin ea = down;   next = down; end
        endcase
    end
endmodule

// File: rtl/bytelane_access.sv
// Byte-lane data access unit. It decodes byte and word requests onto a
// two-lane store and formats read data, zero-extending byte reads.
// It raises an address-error trap on odd word addresses: the read still
// completes and the write is dropped. It also provides the pointer step unit.
// Assumes single-cycle requests and synchronous active-low reset.
module bytelane_access
    import bytelane_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic          req_ypath,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic [15:0]   rd_data,
    output logic          rd_valid,
    output logic          trap_pulse,
    output logic [AW-1:0] trap_addr,
    output logic          trap_is_write,
    output logic          trap_held,
    input  logic          trap_clear,
    input  logic [AW-1:0] ptr_in,
    input  logic [1:0]    ptr_mode,
    input  logic          ptr_byte,
    output logic [AW-1:0] ptr_ea,
    output logic [AW-1:0] ptr_next
);
    localparam int IDX_W = AW - 1;
    localparam int WORDS = 2 ** IDX_W;

    logic             acc_write;
    logic             acc_byte;
    logic             misaligned;
    logic             rd_en;
    logic [LANES-1:0] lane_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic             rd_byte_q;
    logic             rd_hi_q;

    bytelane_align u_align (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_byte  (req_byte),
        .req_ypath (req_ypath),
        .addr_lsb  (req_addr[0]),
        .acc_write (acc_write),
        .acc_byte  (acc_byte),
        .misaligned(misaligned),
        .rd_en     (rd_en),
        .lane_we   (lane_we)
    );

    // Byte writes replicate the low byte so either lane can take it.
    assign mem_wdata = acc_byte ? {LANES{req_wdata[LANE_W-1:0]}} : req_wdata;

    bytelane_mem #(.WORDS(WORDS)) u_mem (
        .clk    (clk),
        .lane_we(lane_we),
        .rd_en  (rd_en),
        .idx    (req_addr[AW-1:1]),
        .wdata  (mem_wdata),
        .rdata  (mem_rdata)
    );

    bytelane_step #(.AW(AW)) u_step (
        .ptr_in (ptr_in),
        .mode   (ptr_mode),
        .is_byte(ptr_byte),
        .ea     (ptr_ea),
        .next   (ptr_next)
    );

    // Read side: remember the size and lane of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_byte_q <= 1'b0;
            rd_hi_q   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_byte_q <= acc_byte;
                rd_hi_q   <= req_addr[0];
            end
        end
    end

    // Read formatting: the selected byte goes to the low lane, zero-extended.
    always_comb begin
        if (rd_byte_q) begin
            rd_data = {8'h00, rd_hi_q ? mem_rdata[15:8] : mem_rdata[7:0]};
        end else begin
            rd_data = mem_rdata;
        end
    end

    // Trap side: one-cycle pulse, fault capture and sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse    <= 1'b0;
            trap_addr     <= '0;
            trap_is_write <= 1'b0;
            trap_held     <= 1'b0;
        end else begin
            trap_pulse <= misaligned;
            if (misaligned) begin
                trap_addr     <= req_addr;
                trap_is_write <= acc_write;
                trap_held     <= 1'b1;
            end else if (trap_clear) begin
                trap_held <= 1'b0;
            end
        end
    end

    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> $past(req_valid && req_addr[0] && (req_ypath || !req_byte)));

    p_held_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> trap_held);

    p_no_write_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[0] && !req_byte) |-> (lane_we == '0));

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_byte && !req_ypath) |-> ($countones(lane_we) == 1));

    p_ypath_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ypath) |-> (lane_we == '0));

    p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_byte && !req_ypath)) |-> (rd_data[15:8] == 8'h00));

    p_read_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[0] && !req_byte) |=> (rd_valid && trap_pulse));

    p_pre_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_mode[1] |-> (ptr_ea == ptr_next));
endmodule

// File: tb/tb_bytelane_access.sv
module tb_bytelane_access;
    localparam int AW    = 7;
    localparam int WORDS = 2 ** (AW - 1);
    localparam int BYTES = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_ypath = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [15:0]   rd_data;
    logic          rd_valid, trap_pulse, trap_is_write, trap_held;
    logic [AW-1:0] trap_addr;
    logic          trap_clear = 1'b0;
    logic [AW-1:0] ptr_in = '0;
    logic [1:0]    ptr_mode = '0;
    logic          ptr_byte = 1'b0;
    logic [AW-1:0] ptr_ea, ptr_next;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] model [WORDS];

    bytelane_access #(.AW(AW)) dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input int salt);
        return 16'((i * 4663 + salt * 911) ^ 16'h5A3C);
    endfunction

    // Drive one request at a negedge, return at the next negedge with it dropped.
    task automatic issue(input logic w, input logic b, input logic y,
                         input logic [AW-1:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = w; req_byte = b; req_ypath = y;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0; req_ypath = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < WORDS; i++) begin
            issue(1'b0, 1'b0, 1'b0, AW'(2 * i), 16'h0);
            chk(rd_valid && rd_data == model[i], tag, rd_data, model[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(rd_valid == 0, "R10 rd_valid", rd_valid, 0);
        chk(trap_pulse == 0, "R10 trap_pulse", trap_pulse, 0);
        chk(trap_held == 0, "R10 trap_held", trap_held, 0);
        chk(trap_is_write == 0, "R10 trap_is_write", trap_is_write, 0);
        chk(trap_addr == 0, "R10 trap_addr", trap_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: word write then word read of every word
        for (int i = 0; i < WORDS; i++) begin
            model[i] = pat(i, 1);
            issue(1'b1, 1'b0, 1'b0, AW'(2 * i), model[i]);
            chk(trap_pulse == 0, "R1 no trap on aligned write", trap_pulse, 0);
        end
        read_all("R1 word read");

        // R2: byte read of every byte address
        for (int a = 0; a < BYTES; a++) begin
            logic [15:0] e;
            e = {8'h00, (a % 2 == 1) ? model[a / 2][15:8] : model[a / 2][7:0]};
            issue(1'b0, 1'b1, 1'b0, AW'(a), 16'h0);
            chk(rd_valid && rd_data == e && !trap_pulse, "R2 byte read", rd_data, e);
        end

        // R3: byte write of every byte address, other lane kept
        for (int a = 0; a < BYTES; a++) begin
            logic [15:0] d;
            d = pat(a, 7);
            if (a % 2 == 1) model[a / 2][15:8] = d[7:0];
            else            model[a / 2][7:0]  = d[7:0];
            issue(1'b1, 1'b1, 1'b0, AW'(a), d);
            chk(trap_pulse == 0, "R3 no trap on byte write", trap_pulse, 0);
        end
        read_all("R3 lane contents");

        // R4 R5 R7: misaligned word reads
        for (int a = 1; a < BYTES; a += 2) begin
            issue(1'b0, 1'b0, 1'b0, AW'(a), 16'h0);
            chk(trap_pulse == 1, "R4 read trap pulse", trap_pulse, 1);
            chk(trap_addr == AW'(a), "R4 read trap addr", trap_addr, a);
            chk(trap_is_write == 0, "R4 read trap flag", trap_is_write, 0);
            chk(trap_held == 1, "R7 held on read fault", trap_held, 1);
            chk(rd_valid && rd_data == model[a / 2], "R5 misaligned read data", rd_data, model[a / 2]);
        end
        @(negedge clk);
        chk(trap_pulse == 0, "R4 pulse one cycle", trap_pulse, 0);
        chk(trap_held == 1, "R7 held after pulse", trap_held, 1);
        trap_clear = 1'b1;
        @(negedge clk);
        trap_clear = 1'b0;
        chk(trap_held == 0, "R7 cleared", trap_held, 0);

        // R4 R6: misaligned word writes leave memory untouched
        for (int a = 1; a < BYTES; a += 2) begin
            issue(1'b1, 1'b0, 1'b0, AW'(a), ~model[a / 2]);
            chk(trap_pulse == 1, "R4 write trap pulse", trap_pulse, 1);
            chk(trap_is_write == 1, "R4 write trap flag", trap_is_write, 1);
            chk(trap_addr == AW'(a), "R4 write trap addr", trap_addr, a);
        end
        read_all("R6 memory unchanged");

        // R7: fault coinciding with clear keeps status
        trap_clear = 1'b1;
        issue(1'b0, 1'b0, 1'b0, AW'(5), 16'h0);
        trap_clear = 1'b0;
        chk(trap_held == 1, "R7 fault beats clear", trap_held, 1);

        // R8: prefetch path ignores byte and write
        for (int i = 0; i < WORDS; i++) begin
            issue(1'b1, 1'b1, 1'b1, AW'(2 * i), 16'hFFFF);
            chk(rd_valid && rd_data == model[i], "R8 ypath word read", rd_data, model[i]);
        end
        issue(1'b1, 1'b1, 1'b1, AW'(9), 16'h0);
        chk(trap_pulse && trap_is_write == 0, "R8 ypath odd traps as read", trap_is_write, 0);
        read_all("R8 no write via ypath");

        // R9: pointer modify over all pointers, modes and sizes
        for (int p = 0; p < BYTES; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [AW-1:0] st, e_ea, e_nx;
                    st = (s == 1) ? AW'(1) : AW'(2);
                    e_nx = (m % 2 == 0) ? AW'(p + st) : AW'(p - st);
                    e_ea = (m >= 2) ? e_nx : AW'(p);
                    ptr_in = AW'(p); ptr_mode = 2'(m); ptr_byte = s[0];
                    #1;
                    chk(ptr_ea == e_ea, "R9 ea", ptr_ea, e_ea);
                    chk(ptr_next == e_nx, "R9 next", ptr_next, e_nx);
                end
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule